// File: doc/BRIEF.md
# ADC Result Window Monitor

This block watches the stream of conversion results that an analog-to-digital converter writes into its result registers and raises a sticky flag for each of two window monitors whenever a fresh result meets that monitor's threshold condition. Each monitor is set up on its own. It has a source index that names the result register it follows, a 3-bit mode code, a low threshold and a high threshold.

A result write arrives as a valid strobe, a register index, a 16-bit data word and a left-adjust qualifier. The block first brings the word back to a right-aligned 12-bit value, so the left-adjust setting never changes the outcome of a comparison. Each monitor then checks the value against its own window, and only in the cycle of a write to its chosen register. A flag stays set until its clear input is pulsed. When a set and a clear fall in the same cycle, the set wins, so a hit is never lost. The flags are meant to feed an interrupt controller.

Top module: `adc_window_monitor`

## Requirements
- R1: The two monitors are independent: a result write may set one monitor's flag and leave the other unchanged, according to each one's own source, mode and thresholds.
- R2: A monitor evaluates a write only when `res_wr_idx` equals its source field; writes to any other result register never set its flag.
- R3: After reset both flags are 0. Mode code 3'b000 disables a monitor, so its flag is never set.
- R4: Mode 3'b001 (below) sets the flag when value < high threshold.
- R5: Mode 3'b010 (above) sets the flag when value > low threshold.
- R6: Mode 3'b011 (inside) sets the flag when low < value < high, with both bounds strict.
- R7: Mode 3'b100 (outside) sets the flag when value <= low or value >= high.
- R8: Mode codes 3'b101, 3'b110 and 3'b111 are reserved and never set the flag.
- R9: When `res_left_adj` is 1 the compared value is `res_wr_data[15:4]`. When it is 0 the compared value is `res_wr_data[11:0]`.
- R10: A hit on the write sampled at clock edge k makes the flag read 1 after edge k. The flag then stays 1 until it is cleared.
- R11: A clear pulse sampled at edge k makes the flag read 0 after edge k, unless the same edge also sees a hit for that monitor, in which case the flag reads 1.
- R12: Without a result write and without a clear, a flag does not change, even if its configuration changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_wr_valid | input | 1 | A result register is written this cycle |
| res_wr_idx | input | 2 | Index of the result register being written |
| res_wr_data | input | 16 | Result word as stored (right- or left-adjusted) |
| res_left_adj | input | 1 | 1: result sits in bits 15:4; 0: in bits 11:0 |
| mon_src | input | 4 | Source index per monitor, monitor m at [2m+1:2m] |
| mon_mode | input | 6 | Mode code per monitor, monitor m at [3m+2:3m] |
| mon_hi | input | 24 | High threshold per monitor, monitor m at [12m+11:12m] |
| mon_lo | input | 24 | Low threshold per monitor, monitor m at [12m+11:12m] |
| flag_clr | input | 2 | Clear pulse per monitor flag |
| win_flag | output | 2 | Sticky window-hit flag per monitor |

## Verification
The bench builds the block with its default parameters: four result registers, two monitors, 12-bit values and 16-bit words. With these values every source index 0 to 3 can be chosen, including an index that no monitor follows, and the extremes 0 and 4095 can be written. The bench drives each mode exactly at its threshold boundaries, puts a clear in the same cycle as a hit, and writes the same 12-bit value both right- and left-adjusted.

// File: rtl/awm_pkg.sv
// Package of shared definitions for the ADC result window monitor.
// Assumes mode codes are 3 bits wide; the code points are fixed by behaviour.
package awm_pkg;

    localparam int MODE_W = 3;

    // Window mode code points; the codes not listed here are reserved.
    typedef enum logic [MODE_W-1:0] {
        WM_OFF     = 3'b000,
        WM_BELOW   = 3'b001,
        WM_ABOVE   = 3'b010,
        WM_INSIDE  = 3'b011,
        WM_OUTSIDE = 3'b100
    } win_mode_e;

endpackage

// File: rtl/awm_align.sv
// Brings a stored result word back to a right-aligned value.
// Assumes a left-adjusted word carries the value in its top RES_W bits.
module awm_align #(
    parameter int RES_W  = 12,
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              left_adj,
    output logic [RES_W-1:0]  value_out
);

    // Select the value bits according to the adjustment setting.
    always_comb begin
        if (left_adj) begin
            value_out = word_in[WORD_W-1 -: RES_W];
        end else begin
            value_out = word_in[RES_W-1:0];
        end
    end

endmodule

// File: rtl/awm_window_eval.sv
// Decides whether one monitor hits on the current result write.
// Assumes value is already right-aligned; a reserved mode never hits.
module awm_window_eval
    import awm_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int SRC_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [SRC_W-1:0]   wr_idx,
    input  logic [RES_W-1:0]   value,
    input  logic [SRC_W-1:0]   src,
    input  logic [MODE_W-1:0]  mode,
    input  logic [RES_W-1:0]   lo,
    input  logic [RES_W-1:0]   hi,
    output logic               hit
);

    logic below_hi;
    logic above_lo;
    logic at_or_below_lo;
    logic at_or_above_hi;
    logic mode_hit;
    logic selected;

    // Threshold comparators shared by all modes.
    always_comb begin
        below_hi       = value <  hi;
        above_lo       = value >  lo;
        at_or_below_lo = value <= lo;
        at_or_above_hi = value >= hi;
    end

    // Mode decode on the comparator outputs.
    always_comb begin
        case (mode)
            WM_BELOW:   mode_hit = below_hi;
            WM_ABOVE:   mode_hit = above_lo;
            WM_INSIDE:  mode_hit = above_lo & below_hi;
            WM_OUTSIDE: mode_hit = at_or_below_lo | at_or_above_hi;
            default:    mode_hit = 1'b0;
        endcase
    end

    // Gate by a write to the watched result register.
    always_comb begin
        selected = wr_valid && (wr_idx == src);
        hit      = selected & mode_hit;
    end

    // R2: a write to another register never produces a hit
    assert_src_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx != src) |-> !hit);

    // R3: the disabled mode never hits
    assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WM_OFF) |-> !hit);

    // R8: reserved codes never hit
    assert_reserved_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode > WM_OUTSIDE) |-> !hit);

    // R6: an inside hit lies strictly within the window
    assert_inside_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == WM_INSIDE) |-> (value > lo && value < hi));

endmodule

// File: rtl/awm_flag.sv
// Sticky hit flag for one monitor; a set in the same cycle as a clear wins.
// Assumes set and clr are synchronous single-cycle qualifiers.
module awm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Hold, set or clear the flag, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // R10: a hit shows on the flag after the sampling edge
    assert_set_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    // R10: a set flag stays set without a clear
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R11: a clear without a hit drops the flag
    assert_clear_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/adc_window_monitor.sv
// Two-monitor window comparator over ADC result register writes.
// Each monitor follows one result register and sets a sticky flag when a
// new result meets its mode condition. Assumes at most one result write
// per cycle and synchronous, active-low reset.
module adc_window_monitor
    import awm_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int NUM_MON = 2,
    parameter int RES_W   = 12,
    parameter int WORD_W  = 16,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        res_wr_valid,
    input  logic [SRC_W-1:0]            res_wr_idx,
    input  logic [WORD_W-1:0]           res_wr_data,
    input  logic                        res_left_adj,
    input  logic [NUM_MON*SRC_W-1:0]    mon_src,
    input  logic [NUM_MON*MODE_W-1:0]   mon_mode,
    input  logic [NUM_MON*RES_W-1:0]    mon_hi,
    input  logic [NUM_MON*RES_W-1:0]    mon_lo,
    input  logic [NUM_MON-1:0]          flag_clr,
    output logic [NUM_MON-1:0]          win_flag
);

    logic [RES_W-1:0]   aligned;
    logic [NUM_MON-1:0] hit;

    awm_align #(.RES_W(RES_W), .WORD_W(WORD_W)) align_i (
        .word_in  (res_wr_data),
        .left_adj (res_left_adj),
        .value_out(aligned)
    );

    // One evaluator and one flag per monitor.
    for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
        awm_window_eval #(.RES_W(RES_W), .SRC_W(SRC_W)) eval_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_valid(res_wr_valid),
            .wr_idx  (res_wr_idx),
            .value   (aligned),
            .src     (mon_src[m*SRC_W +: SRC_W]),
            .mode    (mon_mode[m*MODE_W +: MODE_W]),
            .lo      (mon_lo[m*RES_W +: RES_W]),
            .hi      (mon_hi[m*RES_W +: RES_W]),
            .hit     (hit[m])
        );

        awm_flag flag_i (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (hit[m]),
            .clr  (flag_clr[m]),
            .flag (win_flag[m])
        );

        // R12: no write and no clear leaves the flag unchanged
        assert_quiet_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (!res_wr_valid && !flag_clr[m]) |=> $stable(win_flag[m]));
    end

    // R3: flags read zero in the cycle after reset
    assert_reset_clear_R3: assert property (@(posedge clk)
        !rst_n |=> (win_flag == '0));

endmodule

// File: tb/adc_window_monitor_tb.sv
// Scoreboard bench: the driver predicts flags and queues them, the monitor
// compares them against the design after each sampling edge.
module adc_window_monitor_tb_top;

    localparam int NUM_MON = 2;
    localparam int RES_W   = 12;
    localparam int WORD_W  = 16;
    localparam int SRC_W   = 2;

    logic                      clk;
    logic                      rst_n;
    logic                      res_wr_valid;
    logic [SRC_W-1:0]          res_wr_idx;
    logic [WORD_W-1:0]         res_wr_data;
    logic                      res_left_adj;
    logic [NUM_MON*SRC_W-1:0]  mon_src;
    logic [NUM_MON*3-1:0]      mon_mode;
    logic [NUM_MON*RES_W-1:0]  mon_hi;
    logic [NUM_MON*RES_W-1:0]  mon_lo;
    logic [NUM_MON-1:0]        flag_clr;
    logic [NUM_MON-1:0]        win_flag;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    typedef struct {
        logic [NUM_MON-1:0] flags;
        string              tag;
    } exp_t;

    exp_t               sb_q[$];
    logic [NUM_MON-1:0] model;

    adc_window_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .res_wr_valid(res_wr_valid),
        .res_wr_idx(res_wr_idx), .res_wr_data(res_wr_data),
        .res_left_adj(res_left_adj), .mon_src(mon_src), .mon_mode(mon_mode),
        .mon_hi(mon_hi), .mon_lo(mon_lo), .flag_clr(flag_clr),
        .win_flag(win_flag)
    );

    // 50 MHz clock
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Condition taken from the mode requirements R3..R8
    function automatic bit mode_says(input logic [2:0] md, input int v,
                                     input int lo, input int hi);
        case (md)
            3'b001:  return v < hi;
            3'b010:  return v > lo;
            3'b011:  return (v > lo) && (v < hi);
            3'b100:  return (v <= lo) || (v >= hi);
            default: return 0;
        endcase
    endfunction

    task automatic config_mon(input int m, input int src, input logic [2:0] md,
                              input int lo, input int hi);
        mon_src[m*SRC_W +: SRC_W] = SRC_W'(src);
        mon_mode[m*3 +: 3]        = md;
        mon_lo[m*RES_W +: RES_W]  = RES_W'(lo);
        mon_hi[m*RES_W +: RES_W]  = RES_W'(hi);
    endtask

    // One driven cycle: apply inputs, predict flags, queue the prediction.
    task automatic step(input bit vld, input int idx, input logic [15:0] data,
                        input bit ladj, input logic [1:0] clr, input string tag);
        int v;
        @(negedge clk);
        res_wr_valid = vld;
        res_wr_idx   = SRC_W'(idx);
        res_wr_data  = data;
        res_left_adj = ladj;
        flag_clr     = clr;
        v = ladj ? int'(data[15:4]) : int'(data[11:0]);   // R9 alignment
        for (int m = 0; m < NUM_MON; m++) begin
            bit s;
            s = vld && (idx == int'(mon_src[m*SRC_W +: SRC_W])) &&
                mode_says(mon_mode[m*3 +: 3], v,
                          int'(mon_lo[m*RES_W +: RES_W]),
                          int'(mon_hi[m*RES_W +: RES_W]));
            if (s)           model[m] = 1'b1;
            else if (clr[m]) model[m] = 1'b0;
        end
        @(posedge clk);
        #1;
        sb_q.push_back('{flags: model, tag: tag});
    endtask

    task automatic wr(input int idx, input int val, input string tag);
        step(1'b1, idx, 16'(val), 1'b0, 2'b00, tag);
    endtask

    task automatic clear_all();
        step(1'b0, 0, 16'h0, 1'b0, 2'b11, "R11 clear all");
    endtask

    // Monitor: compare the design against queued predictions.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (win_flag !== e.flags) begin
                failures++;
                $display("FAIL %s: win_flag=%b expected=%b", e.tag, win_flag, e.flags);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model        = '0;
        rst_n        = 1'b0;
        res_wr_valid = 1'b0;
        res_wr_idx   = '0;
        res_wr_data  = '0;
        res_left_adj = 1'b0;
        flag_clr     = '0;
        mon_src      = '0;
        mon_mode     = '0;
        mon_hi       = '0;
        mon_lo       = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        step(1'b0, 0, 16'h0, 1'b0, 2'b00, "R3 reset state");

        config_mon(0, 0, 3'b001, 0, 100);
        config_mon(1, 1, 3'b010, 200, 4095);
        wr(0, 100, "R4 below at high boundary");
        wr(0, 99,  "R4 below hit");
        wr(1, 200, "R5 above at low boundary, R10 sticky");
        wr(1, 201, "R5 above hit");
        step(1'b0, 0, 16'h0, 1'b0, 2'b00, "R10 flags hold");
        clear_all();
        wr(2, 5,   "R2 unwatched register");
        wr(1, 50,  "R2 monitor0 ignores register1");

        config_mon(0, 2, 3'b011, 10, 20);
        wr(2, 10, "R6 inside at low bound");
        wr(2, 20, "R6 inside at high bound");
        wr(2, 15, "R6 inside hit");
        clear_all();
        step(1'b1, 2, 16'd15, 1'b0, 2'b01, "R11 set beats clear");
        clear_all();

        config_mon(1, 3, 3'b100, 100, 200);
        wr(3, 150,  "R7 outside mid window");
        wr(3, 101,  "R7 outside just above low");
        wr(3, 100,  "R7 outside at low");
        clear_all();
        wr(3, 199,  "R7 outside just below high");
        wr(3, 200,  "R7 outside at high");
        clear_all();
        wr(3, 4095, "R7 outside at maximum");
        clear_all();

        config_mon(0, 0, 3'b001, 0, 16);
        step(1'b1, 0, 16'h00F0, 1'b1, 2'b00, "R9 left-adjusted 15 hits");
        clear_all();
        step(1'b1, 0, 16'h0100, 1'b1, 2'b00, "R9 left-adjusted 16 no hit");
        step(1'b1, 0, 16'h0100, 1'b0, 2'b00, "R9 right-aligned 256 no hit");
        step(1'b1, 0, 16'h000F, 1'b0, 2'b00, "R9 right-aligned 15 hits");
        clear_all();

        for (int c = 5; c < 8; c++) begin
            config_mon(0, 0, 3'(c), 100, 200);
            wr(0, 0,    "R8 reserved mode low value");
            wr(0, 4095, "R8 reserved mode high value");
            wr(0, 150,  "R8 reserved mode mid value");
        end
        config_mon(0, 0, 3'b000, 100, 200);
        wr(0, 0,    "R3 disabled mode");
        wr(0, 4095, "R3 disabled mode");

        config_mon(0, 1, 3'b001, 0, 50);
        config_mon(1, 1, 3'b010, 300, 4095);
        wr(1, 20,  "R1 same source, only monitor0");
        wr(1, 400, "R1 same source, monitor1 joins");
        clear_all();

        config_mon(0, 1, 3'b001, 0, 4095);
        step(1'b0, 1, 16'd5, 1'b0, 2'b00, "R12 config change without write");
        step(1'b0, 1, 16'd5, 1'b0, 2'b00, "R12 idle hold");
        wr(1, 5, "R12 next write evaluates");
        step(1'b0, 0, 16'h0, 1'b0, 2'b00, "R12 hold after hit");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule